// File: doc/BRIEF.md
# Compand-Bit Power Assessor

This block estimates the input level of a delta-modulation voice encoder from its output bit stream alone. It watches every valid encoder bit and scores one compand event whenever that bit and the two valid bits before it are equal, which is a run of three zeros or three ones. Events are tallied over consecutive windows of 1024 valid bits. When a window closes, the tally is turned into a 5-bit quasi-logarithmic power code. The code is latched and a ready flag is raised for the interrupt logic.

Software reads the code after the ready flag rises. The status read pulses the clear input, which drops the flag. The latched code stays put until the next window closes. A general reset returns everything to its initial state.

Two small state machines do the work. The history machine has the states H_EMPTY, H_ONE and H_FULL. It moves H_EMPTY to H_ONE to H_FULL, one step on each valid bit, and it stays in H_FULL until reset. The window machine has the states W_COUNT and W_SAT. It moves W_COUNT to W_SAT when the tally reaches 512, and it returns from either state to W_COUNT when the window closes.

Top module: `cbit_power_meter`

## Requirements
- R1: A valid bit scores one event when it equals the two previous valid bits. A run of k identical valid bits therefore scores k-2 events, and a run of 1 or 2 bits scores none.
- R2: A cycle with `enc_vld` low has no effect. It does not change the bit history, the event tally or the position in the window, whatever `enc_bit` carries.
- R3: Every 1024th valid bit closes a window. `pwr_code` and `pwr_rdy` change on the same clock edge that samples that bit. The event scored by that bit is included in the tally. Before that edge, `pwr_rdy` stays low once it has been cleared.
- R4: The tally restarts from zero in each window and saturates at 512. Any window with 512 or more events reports code 31.
- R5: The code is the index of the highest threshold not above the tally. Codes 0 to 7 have thresholds 0 to 7. Codes 8 to 16 have thresholds 8 to 24 in steps of 2. Codes 17 to 24 have thresholds 32 to 88 in steps of 8. Codes 25 to 31 have thresholds 128 to 512 in steps of 64.
- R6: The bit history carries across window boundaries. A window whose first bit completes a run begun in the previous window scores that event in the new window.
- R7: A high `rdy_clr` on a clock edge clears `pwr_rdy`, unless the same edge closes a window, in which case the flag is set. `pwr_code` holds its value between window closes.
- R8: An active-low `rst_n` clears `pwr_code` to 0 and `pwr_rdy` to 0. It also empties the bit history and returns the window position and the tally to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low general reset |
| enc_bit | input | 1 | Encoder output bit |
| enc_vld | input | 1 | High when `enc_bit` carries a new encoder bit |
| rdy_clr | input | 1 | Clear pulse from the status read |
| pwr_code | output | 5 | Latched quasi-logarithmic power code |
| pwr_rdy | output | 1 | Power reading ready flag |

## Verification
A corrupted history register or a stuck state in the history machine changes the event tally. This shows in the code latched at the close of the very next window, and the vector table sets up runs that sit on threshold edges so that an error of one event moves the code. A slip in the window position counter makes the ready flag rise early or late, which the bench catches one bit before the expected close. A saturation or mapping fault shows as a wrong code for a window whose tally is chosen just below or at a step boundary. Idle cycles carrying garbage, a mid-window reset and a run that straddles a window boundary each expose history or position state that must be kept or dropped.

// File: rtl/cbpm_pkg.sv
package cbpm_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        H_EMPTY = 2'd0,
        H_ONE   = 2'd1,
        H_FULL  = 2'd2
    } hist_st_e;

    typedef enum logic {
        W_COUNT = 1'b0,
        W_SAT   = 1'b1
    } win_st_e;

    // Lowest tally that maps to code idx on the quasi-logarithmic scale
    function automatic int unsigned code_floor(input int unsigned idx);
        if (idx < 8)
            return idx;
        else if (idx < 17)
            return 8 + 2 * (idx - 8);
        else if (idx < 25)
            return 32 + 8 * (idx - 17);
        else
            return 128 + 64 * (idx - 25);
    endfunction

endpackage

// File: rtl/cbpm_detect.sv
module cbpm_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic vld_i,
    output logic evt_o
);
    import cbpm_pkg::*;

    hist_st_e st, st_nxt;
    logic     h_new, h_old;

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            H_EMPTY: if (vld_i) st_nxt = H_ONE;
            H_ONE:   if (vld_i) st_nxt = H_FULL;
            H_FULL:  st_nxt = H_FULL;
            default: st_nxt = H_EMPTY;
        endcase
    end

    // state register and two-deep history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= H_EMPTY;
            h_new <= 1'b0;
            h_old <= 1'b0;
        end else begin
            st <= st_nxt;
            if (vld_i) begin
                h_old <= h_new;
                h_new <= bit_i;
            end
        end
    end

    // output logic: event when the current bit completes a triple
    always_comb begin
        evt_o = 1'b0;
        unique case (st)
            H_EMPTY: evt_o = 1'b0;
            H_ONE:   evt_o = 1'b0;
            H_FULL:  evt_o = vld_i && (bit_i == h_new) && (h_new == h_old);
            default: evt_o = 1'b0;
        endcase
    end

    // R2
    hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable({h_new, h_old}) && $stable(st));

    // R1
    hist_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == H_ONE && vld_i) |=> (st == H_FULL));

endmodule

// File: rtl/cbpm_code_map.sv
module cbpm_code_map #(
    parameter int CNT_W  = 10,
    parameter int CODE_W = 5
) (
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int NCODE = 2 ** CODE_W;

    logic [NCODE-2:0] ge;

    for (genvar k = 1; k < NCODE; k++) begin : g_thr
        localparam logic [CNT_W-1:0] THR = CNT_W'(cbpm_pkg::code_floor(k));
        assign ge[k-1] = (cnt_i >= THR);
    end

    // thermometer of passed thresholds, summed into the code
    always_comb begin
        code_o = '0;
        for (int k = 0; k < NCODE - 1; k++)
            code_o = code_o + CODE_W'(ge[k]);
    end

endmodule

// File: rtl/cbpm_window.sv
module cbpm_window #(
    parameter int WIN_BITS = 1024,
    parameter int CNT_MAX  = 512,
    parameter int CODE_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              evt_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] code_o,
    output logic              rdy_o
);
    import cbpm_pkg::*;

    localparam int POS_W = $clog2(WIN_BITS);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIN_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);

    win_st_e           st, st_nxt;
    logic [POS_W-1:0]  pos, pos_nxt;
    logic [CNT_W-1:0]  cnt, cnt_fin, cnt_nxt;
    logic [CODE_W-1:0] code_fin;
    logic              win_end;

    assign win_end = vld_i && (pos == POS_LAST);

    // next-state logic
    always_comb begin
        st_nxt  = st;
        cnt_fin = cnt;
        unique case (st)
            W_COUNT: begin
                cnt_fin = cnt + CNT_W'(evt_i);
                if (cnt_fin == CNT_TOP)
                    st_nxt = W_SAT;
            end
            W_SAT: begin
                cnt_fin = CNT_TOP;
                st_nxt  = W_SAT;
            end
            default: st_nxt = W_COUNT;
        endcase
        cnt_nxt = cnt_fin;
        if (win_end) begin
            st_nxt  = W_COUNT;
            cnt_nxt = '0;
        end
        if (!vld_i)
            pos_nxt = pos;
        else if (win_end)
            pos_nxt = '0;
        else
            pos_nxt = pos + POS_W'(1);
    end

    cbpm_code_map #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_map (
        .cnt_i  (cnt_fin),
        .code_o (code_fin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_COUNT;
            pos <= '0;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            pos <= pos_nxt;
            cnt <= cnt_nxt;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            rdy_o  <= 1'b0;
        end else begin
            if (win_end) begin
                code_o <= code_fin;
                rdy_o  <= 1'b1;
            end else if (clr_i) begin
                rdy_o  <= 1'b0;
            end
        end
    end

    // R4
    cnt_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_TOP);

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_SAT && !win_end) |=> (cnt == CNT_TOP));

    // R3
    pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (pos == '0) && (cnt == '0) && rdy_o);

    // R3
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(win_end));

    // R7
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !win_end) |=> !rdy_o);

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(code_o));

endmodule

// File: rtl/cbit_power_meter.sv
module cbit_power_meter #(
    parameter int WIN_BITS = 1024,
    parameter int CNT_MAX  = 512,
    parameter int CODE_W   = cbpm_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_bit,
    input  logic              enc_vld,
    input  logic              rdy_clr,
    output logic [CODE_W-1:0] pwr_code,
    output logic              pwr_rdy
);
    logic evt;

    cbpm_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (enc_bit),
        .vld_i (enc_vld),
        .evt_o (evt)
    );

    cbpm_window #(
        .WIN_BITS (WIN_BITS),
        .CNT_MAX  (CNT_MAX),
        .CODE_W   (CODE_W)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (enc_vld),
        .evt_i  (evt),
        .clr_i  (rdy_clr),
        .code_o (pwr_code),
        .rdy_o  (pwr_rdy)
    );

    // R1
    evt_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> enc_vld);

endmodule

// File: tb/cbit_power_meter_test.sv
module cbit_power_meter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 1024;
    localparam int NVEC       = 16;

    // entry: run length (11) | gap flag (1) | clear on last bit (1) | expected code (5)
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {11'd0,    1'b0, 1'b0, 5'd0},
        {11'd3,    1'b0, 1'b0, 5'd1},
        {11'd9,    1'b0, 1'b0, 5'd7},
        {11'd10,   1'b0, 1'b0, 5'd8},
        {11'd11,   1'b1, 1'b0, 5'd8},
        {11'd26,   1'b0, 1'b0, 5'd16},
        {11'd33,   1'b0, 1'b1, 5'd16},
        {11'd34,   1'b0, 1'b0, 5'd17},
        {11'd90,   1'b0, 1'b0, 5'd24},
        {11'd129,  1'b1, 1'b0, 5'd24},
        {11'd130,  1'b0, 1'b0, 5'd25},
        {11'd193,  1'b0, 1'b0, 5'd25},
        {11'd194,  1'b0, 1'b0, 5'd26},
        {11'd513,  1'b0, 1'b0, 5'd30},
        {11'd514,  1'b0, 1'b0, 5'd31},
        {11'd1024, 1'b0, 1'b0, 5'd31}
    };

    logic       clk;
    logic       rst_n;
    logic       enc_bit;
    logic       enc_vld;
    logic       rdy_clr;
    logic [4:0] pwr_code;
    logic       pwr_rdy;

    int   n_run;
    int   n_fail;
    bit   done;
    logic last_bit;
    int   prev_code;

    cbit_power_meter uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_bit  (enc_bit),
        .enc_vld  (enc_vld),
        .rdy_clr  (rdy_clr),
        .pwr_code (pwr_code),
        .pwr_rdy  (pwr_rdy)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full window: a run of len equal bits first, then alternating bits
    task automatic run_window(input int len, input bit gap, input bit clr_last,
                              input bit first_same);
        logic v;
        logic b;
        v = first_same ? last_bit : ~last_bit;
        for (int i = 0; i < WIN; i++) begin
            if (gap && (i % 5 == 2)) begin
                @(negedge clk);
                enc_vld = 1'b0;
                rdy_clr = 1'b0;
                enc_bit = (i < len) ? ~v : last_bit;
            end
            @(negedge clk);
            if (i == 512 || i == WIN - 1) begin
                check(pwr_rdy == 1'b0, "R3 ready early", int'(pwr_rdy), 0);
                check(int'(pwr_code) == prev_code, "R7 code hold", int'(pwr_code), prev_code);
            end
            b = (i < len) ? v : ~last_bit;
            enc_bit  = b;
            enc_vld  = 1'b1;
            rdy_clr  = clr_last && (i == WIN - 1);
            last_bit = b;
        end
        @(negedge clk);
        enc_vld = 1'b0;
        rdy_clr = 1'b0;
    endtask

    task automatic end_window(input int exp, input string req);
        check(pwr_rdy == 1'b1, req, int'(pwr_rdy), 1);
        check(int'(pwr_code) == exp, req, int'(pwr_code), exp);
        rdy_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0;
        check(pwr_rdy == 1'b0, "R7 clear", int'(pwr_rdy), 0);
        check(int'(pwr_code) == exp, "R7 code after clear", int'(pwr_code), exp);
        prev_code = exp;
    endtask

    initial begin
        n_run    = 0;
        n_fail   = 0;
        done     = 1'b0;
        last_bit = 1'b0;
        prev_code = 0;
        rst_n   = 1'b0;
        enc_bit = 1'b0;
        enc_vld = 1'b0;
        rdy_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(pwr_code == 5'd0, "R8 reset code", int'(pwr_code), 0);
        check(pwr_rdy == 1'b0, "R8 reset ready", int'(pwr_rdy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NVEC; n++) begin
            int    len;
            bit    gap;
            bit    clrl;
            int    exp;
            string tag;
            len  = int'(VEC[n][17:7]);
            gap  = VEC[n][6];
            clrl = VEC[n][5];
            exp  = int'(VEC[n][4:0]);
            if (gap)              tag = "R2 idle cycles";
            else if (clrl)        tag = "R7 set over clear";
            else if (len >= 514)  tag = "R4 saturation";
            else if (len == 3)    tag = "R1 single triple";
            else                  tag = "R5 code scale";
            run_window(len, gap, clrl, 1'b0);
            end_window(exp, tag);
        end

        // R6: previous window ended with two equal bits; first bit repeats them
        run_window(1, 1'b0, 1'b0, 1'b1);
        end_window(1, "R6 history across boundary");

        // R8: reset in the middle of a window full of events
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            enc_bit = 1'b1;
            enc_vld = 1'b1;
        end
        @(negedge clk);
        enc_vld = 1'b0;
        rst_n   = 1'b0;
        repeat (2) @(negedge clk);
        check(pwr_code == 5'd0, "R8 mid-window reset code", int'(pwr_code), 0);
        check(pwr_rdy == 1'b0, "R8 mid-window reset ready", int'(pwr_rdy), 0);
        rst_n = 1'b1;
        prev_code = 0;
        @(negedge clk);
        run_window(5, 1'b0, 1'b0, 1'b0);
        end_window(3, "R8 window restart after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule